// File: doc/BRIEF.md
# Inter-Processor Mailbox Hub

This block lets processors on one chip pass 32-bit words to each other through four small hardware queues. Every queue sits behind one message register on a simple register bus. A write to that register appends a word to the queue. A read with the read strobe set returns the oldest word and removes it. The queues form send/reply pairs: queue 0 carries traffic from the host to a first peer and queue 1 carries that peer's replies. Queues 2 and 3 serve a second peer in the same way.

Every queue has two status registers. One gives its fill level and the other flags when it is full. Each user (two by default) has its own event status register and its own interrupt mask. Every queue drives two event bits in each user's status: "has data" and "has room". The user's interrupt line is high while any unmasked event bit is set. Software acknowledges events by writing ones to the status register. A build parameter selects the register layout:

- Direct layout: the mask is written as a whole value.
- Split layout: the mask has separate set and clear addresses, and each user's status and mask registers are spaced 16 bytes apart.

Top module: `ipc_mailbox_hub`

## Requirements
- R1: Address 0x000 reads a constant with the major revision in bits 7:4 and the minor revision in bits 3:0 (default 1 and 2, so 0x12). Writes to it have no effect.
- R2: A write to 0x040+4m appends the write data to queue m. A read of 0x040+4m with bus_re high returns the oldest word and removes it, so words come out in the order they went in. Each queue holds 4 words.
- R3: A write to a full queue is discarded. The fill level and the stored words do not change.
- R4: A read with bus_re of an empty queue returns zero and leaves the queue empty.
- R5: Address 0x0C0+4m reads the fill level of queue m. Address 0x080+4m reads 1 while queue m is full and 0 otherwise.
- R6: In every user's event status, bit 2m is set on each clock edge where queue m is non-empty, and bit 2m+1 is set on each clock edge where queue m is not full. Set bits stay set until software clears them.
- R7: Writing a mask to a user's status register clears exactly the bits that are one in the mask. A bit whose set condition holds in that same cycle stays set. The status of other users does not change.
- R8: Line irq_out[u] is high exactly when some bit is set in both the status and the mask of user u.
- R9: In the direct layout (ALT_MAP=0), user u's status is at 0x100+8u and its mask is at 0x104+8u. A write to the mask address replaces the whole mask.
- R10: In the split layout (ALT_MAP=1), user u's status is at 0x104+0x10u. Writing ones to 0x108+0x10u sets mask bits, and writing ones to 0x10C+0x10u clears mask bits. Both addresses read back the mask.
- R11: While reset is held, every queue is empty and all status bits, mask bits and interrupt lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (9) | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe; on a message register it removes the word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, valid in the same cycle |
| irq_out | output | NUM_USER (2) | Interrupt line for each user |

## Verification
The assertions assume that bus_we and bus_re are never both high in one cycle. They also assume that only one register is addressed per cycle, so a queue never sees a write and a read on the same edge. The bench drives one access at a time and leaves an idle cycle after each one, which keeps within these assumptions.

The event checks assume that the status bits sample queue state one edge late. For that reason every status or interrupt read happens at least two edges after the access that changed a queue. The bench drives both layouts through separate instances, so each instance sees only the addresses that belong to its own map.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int REV_OFS  = 'h000;
  localparam int MSG_BASE = 'h040;
  localparam int FST_BASE = 'h080;
  localparam int MST_BASE = 'h0C0;

  // Per-queue register offsets
  function automatic int msg_ofs(input int m);
    return MSG_BASE + 4 * m;
  endfunction

  function automatic int full_ofs(input int m);
    return FST_BASE + 4 * m;
  endfunction

  function automatic int level_ofs(input int m);
    return MST_BASE + 4 * m;
  endfunction

  // Per-user register offsets; alt selects the split mask layout
  function automatic int stat_ofs(input int u, input bit alt);
    return alt ? ('h104 + 16 * u) : ('h100 + 8 * u);
  endfunction

  function automatic int mask_ofs(input int u, input bit alt);
    return alt ? ('h108 + 16 * u) : ('h104 + 8 * u);
  endfunction

  function automatic int mask_clr_ofs(input int u);
    return 'h10C + 16 * u;
  endfunction

  // Event bit positions inside a user's status word
  function automatic int has_data_bit(input int m);
    return 2 * m;
  endfunction

  function automatic int has_room_bit(input int m);
    return 2 * m + 1;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
`timescale 1ns/1ps
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head    = empty ? '0 : store[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/mbx_irq_user.sv
`timescale 1ns/1ps
module mbx_irq_user #(
  parameter int EVT_W   = 8,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_vec,
  input  logic             stat_clr_we,
  input  logic             mask_wr_we,
  input  logic             mask_clr_we,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] status,
  output logic [EVT_W-1:0] mask,
  output logic             irq
);
  logic [EVT_W-1:0] clr_bits, status_nx, mask_nx;

  assign clr_bits  = stat_clr_we ? wdata : '0;
  assign status_nx = (status & ~clr_bits) | set_vec;

  always_comb begin
    mask_nx = mask;
    if (mask_clr_we)     mask_nx = mask & ~wdata;
    else if (mask_wr_we) mask_nx = ALT_MAP ? (mask | wdata) : wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= status_nx;
      mask   <= mask_nx;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/ipc_mailbox_hub.sv
`timescale 1ns/1ps
module ipc_mailbox_hub
  import mbx_pkg::*;
#(
  parameter int NUM_BOX    = 4,
  parameter int NUM_USER   = 2,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 9,
  parameter bit ALT_MAP    = 1'b0,
  parameter int REV_MAJOR  = 1,
  parameter int REV_MINOR  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_USER-1:0] irq_out
);
  localparam int EVT_W = 2 * NUM_BOX;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // Decode strobes
  logic                hit_rev;
  logic [NUM_BOX-1:0]  hit_msg, hit_full, hit_level;
  logic [NUM_USER-1:0] hit_stat, hit_mask, hit_mask_clr;

  // Named events for the checker
  logic [NUM_BOX-1:0]              push_req, pop_req, fifo_full, fifo_empty;
  logic [NUM_BOX-1:0][CNT_W-1:0]   fifo_cnt;
  logic [NUM_BOX-1:0][DATA_W-1:0]  fifo_head;
  logic [EVT_W-1:0]                set_vec;
  logic [NUM_USER-1:0]             clr_we, mask_we, mask_clr_we;
  logic [NUM_USER-1:0][EVT_W-1:0]  evt_status, evt_mask;

  assign hit_rev = (bus_addr == ADDR_W'(REV_OFS));

  for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
    assign hit_msg[m]   = (bus_addr == ADDR_W'(msg_ofs(m)));
    assign hit_full[m]  = (bus_addr == ADDR_W'(full_ofs(m)));
    assign hit_level[m] = (bus_addr == ADDR_W'(level_ofs(m)));
    assign push_req[m]  = bus_we && hit_msg[m];
    assign pop_req[m]   = bus_re && hit_msg[m];

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_req[m]),
      .pop_req  (pop_req[m]),
      .wdata    (bus_wdata),
      .head     (fifo_head[m]),
      .level    (fifo_cnt[m]),
      .full     (fifo_full[m]),
      .empty    (fifo_empty[m])
    );

    assign set_vec[has_data_bit(m)] = !fifo_empty[m];
    assign set_vec[has_room_bit(m)] = !fifo_full[m];
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    assign hit_stat[u] = (bus_addr == ADDR_W'(stat_ofs(u, ALT_MAP)));
    assign hit_mask[u] = (bus_addr == ADDR_W'(mask_ofs(u, ALT_MAP)));
    if (ALT_MAP) begin : g_split
      assign hit_mask_clr[u] = (bus_addr == ADDR_W'(mask_clr_ofs(u)));
    end else begin : g_direct
      assign hit_mask_clr[u] = 1'b0;
    end
    assign clr_we[u]      = bus_we && hit_stat[u];
    assign mask_we[u]     = bus_we && hit_mask[u];
    assign mask_clr_we[u] = bus_we && hit_mask_clr[u];

    mbx_irq_user #(.EVT_W(EVT_W), .ALT_MAP(ALT_MAP)) user_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_vec     (set_vec),
      .stat_clr_we (clr_we[u]),
      .mask_wr_we  (mask_we[u]),
      .mask_clr_we (mask_clr_we[u]),
      .wdata       (bus_wdata[EVT_W-1:0]),
      .status      (evt_status[u]),
      .mask        (evt_mask[u]),
      .irq         (irq_out[u])
    );
  end

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (hit_rev) bus_rdata = DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
    for (int m = 0; m < NUM_BOX; m++) begin
      if (hit_msg[m])   bus_rdata = fifo_head[m];
      if (hit_full[m])  bus_rdata = DATA_W'(fifo_full[m]);
      if (hit_level[m]) bus_rdata = DATA_W'(fifo_cnt[m]);
    end
    for (int u = 0; u < NUM_USER; u++) begin
      if (hit_stat[u])                    bus_rdata = DATA_W'(evt_status[u]);
      if (hit_mask[u] || hit_mask_clr[u]) bus_rdata = DATA_W'(evt_mask[u]);
    end
  end
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
  parameter int NUM_BOX    = 4,
  parameter int NUM_USER   = 2,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 9,
  parameter int REV_MAJOR  = 1,
  parameter int REV_MINOR  = 2,
  localparam int EVT_W = 2 * NUM_BOX,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic [DATA_W-1:0]              bus_rdata,
  input logic [NUM_USER-1:0]            irq_out,
  input logic [NUM_BOX-1:0]             push_req,
  input logic [NUM_BOX-1:0]             pop_req,
  input logic [NUM_BOX-1:0]             fifo_full,
  input logic [NUM_BOX-1:0]             fifo_empty,
  input logic [NUM_BOX-1:0][CNT_W-1:0]  fifo_cnt,
  input logic [NUM_USER-1:0]            clr_we,
  input logic [NUM_USER-1:0][EVT_W-1:0] evt_status,
  input logic [NUM_USER-1:0][EVT_W-1:0] evt_mask
);
  assert_rev_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == '0 |-> bus_rdata == DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)}));

  for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt[m] <= CNT_W'(FIFO_DEPTH));
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push_req[m] && fifo_full[m] |=> $stable(fifo_cnt[m]));
    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req[m] && fifo_empty[m] |-> bus_rdata == '0);
    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req[m] && fifo_empty[m] |=> fifo_empty[m]);
    for (genvar u = 0; u < NUM_USER; u++) begin : g_user
      assert_data_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty[m] |=> evt_status[u][2*m]);
      assert_room_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_full[m] |=> evt_status[u][2*m+1]);
      assert_clr_only_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_status[u][2*m]) |-> $past(clr_we[u] && bus_wdata[2*m]));
    end
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_irq
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_mask[u] == '0 |-> !irq_out[u]);
  end
endmodule

bind ipc_mailbox_hub mbx_checker #(
  .NUM_BOX(NUM_BOX), .NUM_USER(NUM_USER), .DATA_W(DATA_W),
  .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W),
  .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_cnt   (fifo_cnt),
  .clr_we     (clr_we),
  .evt_status (evt_status),
  .evt_mask   (evt_mask)
);

// File: tb/ipc_mailbox_hub_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_d, rdata_s;
  logic [1:0]  irq_d, irq_s;
  int          checks = 0, fails = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  ipc_mailbox_hub #(.ALT_MAP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we && !sel),
    .bus_re(re && !sel), .bus_wdata(wdata), .bus_rdata(rdata_d), .irq_out(irq_d));

  ipc_mailbox_hub #(.ALT_MAP(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we && sel),
    .bus_re(re && sel), .bus_wdata(wdata), .bus_rdata(rdata_s), .irq_out(irq_s));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when a read is on the bus
  always @(negedge clk) begin
    #2;
    if (re && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(sel ? rdata_s : rdata_d, e, t);
    end
  end

  task automatic wr(input bit s, input int a, input logic [31:0] d);
    @(negedge clk);
    sel = s; addr = 9'(a); wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input bit s, input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    sel = s; addr = 9'(a); we = 1'b0; re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_irq(input bit s, input logic [1:0] e, input string t);
    @(negedge clk);
    #2;
    check(32'(s ? irq_s : irq_d), 32'(e), t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    rd(0, 'h100, 32'h0, "R11 status during reset");
    rd(0, 'h104, 32'h0, "R11 mask during reset");
    rd(0, 'h0C0, 32'h0, "R11 level during reset");
    chk_irq(0, 2'b00, "R11 irq during reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: revision constant, write ignored
    rd(0, 'h000, 32'h12, "R1 revision");
    wr(0, 'h000, 32'hFFFF_FFFF);
    rd(0, 'h000, 32'h12, "R1 revision after write");

    // R6: all queues empty, so only has-room bits (odd) set
    rd(0, 'h100, 32'hAA, "R6 user0 idle events");
    rd(0, 'h108, 32'hAA, "R6 user1 idle events");

    // R2/R5: fill queue 0
    wr(0, 'h040, 32'hA1);
    wr(0, 'h040, 32'hB2);
    wr(0, 'h040, 32'hC3);
    rd(0, 'h0C0, 32'd3, "R5 level three");
    rd(0, 'h080, 32'd0, "R5 not full");
    wr(0, 'h040, 32'hD4);
    rd(0, 'h0C0, 32'd4, "R5 level four");
    rd(0, 'h080, 32'd1, "R5 full flag");
    // R3: dropped write
    wr(0, 'h040, 32'hE5);
    rd(0, 'h0C0, 32'd4, "R3 level after dropped write");
    rd(0, 'h100, 32'hAB, "R6 has-data bit 0 set");
    // R2: order, R3: E5 absent
    rd(0, 'h040, 32'hA1, "R2 pop 1");
    rd(0, 'h040, 32'hB2, "R2 pop 2");
    rd(0, 'h040, 32'hC3, "R2 pop 3");
    rd(0, 'h040, 32'hD4, "R3 pop 4 keeps old data");
    // R4: empty read
    rd(0, 'h040, 32'h0, "R4 empty read zero");
    rd(0, 'h0C0, 32'h0, "R4 level stays zero");

    // R7: write-one-to-clear
    wr(0, 'h100, 32'h01);
    rd(0, 'h100, 32'hAA, "R7 bit0 cleared");
    wr(0, 'h100, 32'h02);
    rd(0, 'h100, 32'hAA, "R7 set wins over clear");
    rd(0, 'h108, 32'hAB, "R7 user1 untouched");

    // R8/R9: mask and interrupt, direct layout
    wr(0, 'h044, 32'h5151);
    wr(0, 'h104, 32'h04);
    rd(0, 'h104, 32'h04, "R9 mask readback");
    chk_irq(0, 2'b01, "R8 irq user0 only");
    wr(0, 'h104, 32'h00);
    chk_irq(0, 2'b00, "R9 mask replaced by zero");
    wr(0, 'h104, 32'h04);
    rd(0, 'h100, 32'hAE, "R6 has-data bit 2 set");
    rd(0, 'h044, 32'h5151, "R2 queue 1 pop");
    wr(0, 'h100, 32'h04);
    rd(0, 'h100, 32'hAA, "R7 bit2 cleared");
    chk_irq(0, 2'b00, "R8 irq drops after ack");

    // R10: split layout instance
    rd(1, 'h104, 32'hAA, "R10 split status user0");
    rd(1, 'h114, 32'hAA, "R10 split status user1");
    chk_irq(1, 2'b00, "R10 split irq idle");
    wr(1, 'h108, 32'h02);
    rd(1, 'h108, 32'h02, "R10 mask set");
    rd(1, 'h10C, 32'h02, "R10 clear address reads mask");
    chk_irq(1, 2'b01, "R8 split irq on room event");
    wr(1, 'h108, 32'h08);
    rd(1, 'h108, 32'h0A, "R10 set accumulates");
    wr(1, 'h10C, 32'h02);
    rd(1, 'h108, 32'h08, "R10 clear removes bit");
    chk_irq(1, 2'b01, "R10 irq still on bit3");
    wr(1, 'h10C, 32'h08);
    rd(1, 'h108, 32'h00, "R10 mask empty");
    rd(1, 'h118, 32'h00, "R10 user1 mask untouched");
    chk_irq(1, 2'b00, "R10 irq off");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule